// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This sequencer turns one cache maintenance request, given as a byte interval `[start, end)` and an operation code, into a series of commands for a downstream maintenance queue. It widens the interval to whole cache lines: the start is rounded down to a line boundary and the length is rounded up to a multiple of the line size. It then walks the interval in chunks, and no single chunk is larger than the configured base limit minus one line.

If the interval is so long that rounding it up would wrap the address space, the block sends one whole-cache command instead of range commands. Every command uses a four-signal handshake with the queue. The block holds a command until the queue accepts it, repeats it as often as the queue rejects it, and waits for that command to complete before it sends the next. The sequence always ends with a sync command, which drains the queue's buffers.

`busy_o` covers the whole sequence, from the start request until the sync completes. While `busy_o` is high, new start requests are ignored.

Top module: `cache_range_splitter`

## Requirements
- R1: The first range command carries the start address rounded down to a multiple of LINE_BYTES.
- R2: The span length is end minus the aligned start, modulo 2^ADDR_W, rounded up to a multiple of LINE_BYTES. The sizes of the range commands add up to this span, and each size is a non-zero multiple of LINE_BYTES.
- R3: When the unrounded span is at least 2^ADDR_W − LINE_BYTES, exactly one whole-cache command (kind 1, address 0, size 0) is sent instead of range commands.
- R4: Each range command (kind 0) has size min(remaining, BASE_LIMIT − LINE_BYTES). Its address is the previous command's address plus the previous size.
- R5: When `q_retry_i` is high while `q_valid_o` is high, the same command stays valid in the next cycle with kind, address and size unchanged.
- R6: After the queue accepts a command, `q_valid_o` stays low until `q_done_i` is seen. The next command is valid in the cycle after `q_done_i`.
- R7: After the last range command, or after the whole-cache command, one sync command (kind 2, address 0, size 0) is sent. A span of zero sends only the sync command.
- R8: `busy_o` goes high in the cycle after an accepted start and drops in the cycle after the sync command's done. Range and whole-cache commands carry the request's operation code on `q_op_o` (0 invalidate, 1 clean, 2 flush).
- R9: A start request that arrives while `busy_o` is high has no effect on the commands sent or on the end of the sequence.
- R10: During reset, `busy_o` and `q_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a maintenance sequence (honoured when idle) |
| start_addr_i | input | ADDR_W | First byte of the interval |
| end_addr_i | input | ADDR_W | Byte after the last byte of the interval |
| op_i | input | 2 | Operation code: 0 invalidate, 1 clean, 2 flush |
| busy_o | output | 1 | Sequence in progress |
| q_valid_o | output | 1 | Command offered to the queue |
| q_kind_o | output | 2 | Command kind: 0 range, 1 whole cache, 2 sync |
| q_op_o | output | 2 | Operation code of the command |
| q_addr_o | output | ADDR_W | Range start address (0 for other kinds) |
| q_size_o | output | ADDR_W | Range size in bytes (0 for other kinds) |
| q_accept_i | input | 1 | Queue has registered the offered command |
| q_retry_i | input | 1 | Queue rejected the command; offer it again |
| q_done_i | input | 1 | The accepted command has completed |

## Verification
A wrong cursor or remaining-length register shows on `q_addr_o` or `q_size_o` at the very next command after the fault, because each command is a direct image of that state. A wrong phase shows within one cycle of a handshake event: a lost or early valid after accept, retry or done. A wrong end condition shows as an extra or missing chunk, or a missing sync, which also moves the falling edge of `busy_o`. The bench sweeps start offsets against lengths around the line size, the chunk limit and the wrap threshold in a small configuration, so that each of these faults meets a command whose expected value is computed arithmetically.

// File: rtl/crs_pkg.sv
package crs_pkg;
    typedef enum logic [1:0] {
        CMD_RANGE = 2'd0,
        CMD_ALL   = 2'd1,
        CMD_SYNC  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;
endpackage

// File: rtl/crs_span_prep.sv
module crs_span_prep #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128
) (
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] span_o,
    output logic              whole_o
);
    localparam int LB = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_W   = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LMASK    = LINE_W - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WHOLE_AT = ~LINE_W + ADDR_W'(1);

    logic [ADDR_W-1:0] raw_len;

    always_comb begin
        base_o  = {start_addr_i[ADDR_W-1:LB], {LB{1'b0}}};
        raw_len = end_addr_i - base_o;
        whole_o = (raw_len >= WHOLE_AT);
        span_o  = (raw_len + LMASK) & ~LMASK;
    end
endmodule

// File: rtl/crs_chunk_cap.sv
module crs_chunk_cap #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int BASE_LIMIT = 4194304
) (
    input  logic [ADDR_W-1:0] remain_i,
    output logic [ADDR_W-1:0] chunk_o
);
    localparam logic [ADDR_W-1:0] CHUNK_MAX = ADDR_W'(BASE_LIMIT - LINE_BYTES);

    always_comb begin
        chunk_o = (remain_i > CHUNK_MAX) ? CHUNK_MAX : remain_i;
    end
endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter
    import crs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int BASE_LIMIT = 4194304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic [1:0]        op_i,
    output logic              busy_o,
    output logic              q_valid_o,
    output logic [1:0]        q_kind_o,
    output logic [1:0]        q_op_o,
    output logic [ADDR_W-1:0] q_addr_o,
    output logic [ADDR_W-1:0] q_size_o,
    input  logic              q_accept_i,
    input  logic              q_retry_i,
    input  logic              q_done_i
);
    typedef struct packed {
        phase_e            ph;
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] cursor;
        logic [ADDR_W-1:0] remain;
        logic [1:0]        op;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] base_w, span_w, chunk_w;
    logic              whole_w;

    crs_span_prep #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_prep (
        .start_addr_i (start_addr_i),
        .end_addr_i   (end_addr_i),
        .base_o       (base_w),
        .span_o       (span_w),
        .whole_o      (whole_w)
    );

    crs_chunk_cap #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BASE_LIMIT(BASE_LIMIT)) u_cap (
        .remain_i (seq_q.remain),
        .chunk_o  (chunk_w)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph     = PH_ISSUE;
                    seq_d.cursor = base_w;
                    seq_d.remain = span_w;
                    seq_d.op     = op_i;
                    if (whole_w)
                        seq_d.kind = CMD_ALL;
                    else if (span_w == '0)
                        seq_d.kind = CMD_SYNC;
                    else
                        seq_d.kind = CMD_RANGE;
                end
            end
            PH_ISSUE: begin
                if (!q_retry_i && q_accept_i)
                    seq_d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (q_done_i) begin
                    seq_d.ph = PH_ISSUE;
                    unique case (seq_q.kind)
                        CMD_SYNC: seq_d.ph = PH_IDLE;
                        CMD_ALL:  seq_d.kind = CMD_SYNC;
                        default: begin
                            seq_d.cursor = seq_q.cursor + chunk_w;
                            seq_d.remain = seq_q.remain - chunk_w;
                            if (seq_q.remain == chunk_w)
                                seq_d.kind = CMD_SYNC;
                        end
                    endcase
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.ph     <= PH_IDLE;
            seq_q.kind   <= CMD_SYNC;
            seq_q.cursor <= '0;
            seq_q.remain <= '0;
            seq_q.op     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        busy_o    = (seq_q.ph != PH_IDLE);
        q_valid_o = (seq_q.ph == PH_ISSUE);
        q_kind_o  = seq_q.kind;
        q_op_o    = seq_q.op;
        q_addr_o  = (seq_q.kind == CMD_RANGE) ? seq_q.cursor : '0;
        q_size_o  = (seq_q.kind == CMD_RANGE) ? chunk_w : '0;
    end
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int BASE_LIMIT = 4194304
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              q_valid_o,
    input logic [1:0]        q_kind_o,
    input logic [ADDR_W-1:0] q_addr_o,
    input logic [ADDR_W-1:0] q_size_o,
    input logic              q_accept_i,
    input logic              q_retry_i
);
    localparam int LB = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] CHUNK_MAX = ADDR_W'(BASE_LIMIT - LINE_BYTES);

    // R5: a rejected command is offered again unchanged
    a_r5_retry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o && q_retry_i |=> q_valid_o && $stable(q_kind_o)
                                   && $stable(q_addr_o) && $stable(q_size_o));

    // R6: accepted command is withdrawn until done
    a_r6_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o && q_accept_i && !q_retry_i |=> !q_valid_o);

    // R8: a command is only offered inside a busy sequence
    a_r8_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o |-> busy_o);

    // R4: range size is within the cap, whole lines, non-zero
    a_r4_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o && q_kind_o == 2'd0 |-> q_size_o <= CHUNK_MAX
            && q_size_o != '0 && q_size_o[LB-1:0] == '0);

    // R7: whole-cache and sync commands carry no range
    a_r7_no_range_fields: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o && q_kind_o != 2'd0 |-> q_size_o == '0 && q_addr_o == '0
            && q_kind_o != 2'd3);
endmodule

bind cache_range_splitter crs_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BASE_LIMIT(BASE_LIMIT)
) u_crs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .q_valid_o  (q_valid_o),
    .q_kind_o   (q_kind_o),
    .q_addr_o   (q_addr_o),
    .q_size_o   (q_size_o),
    .q_accept_i (q_accept_i),
    .q_retry_i  (q_retry_i)
);

// File: tb/tb_cache_range_splitter.sv
module tb_cache_range_splitter;
    localparam int AW   = 12;
    localparam int LINE = 16;
    localparam int BASE = 64;
    localparam int CMAX = BASE - LINE;
    localparam int AMSK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW-1:0] end_addr_i = '0;
    logic [1:0]    op_i = '0;
    logic          busy_o, q_valid_o;
    logic [1:0]    q_kind_o, q_op_o;
    logic [AW-1:0] q_addr_o, q_size_o;
    logic          q_accept_i = 1'b0;
    logic          q_retry_i = 1'b0;
    logic          q_done_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cache_range_splitter #(.ADDR_W(AW), .LINE_BYTES(LINE), .BASE_LIMIT(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .end_addr_i(end_addr_i), .op_i(op_i), .busy_o(busy_o), .q_valid_o(q_valid_o),
        .q_kind_o(q_kind_o), .q_op_o(q_op_o), .q_addr_o(q_addr_o), .q_size_o(q_size_o),
        .q_accept_i(q_accept_i), .q_retry_i(q_retry_i), .q_done_i(q_done_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Serve one expected command; called at a negedge where it must be valid.
    task automatic serve(input int kind, input int addr, input int size, input int op,
                         input int retries, input int gap, input bit poke,
                         input string req);
        chk(q_valid_o == 1'b1, "R6", "valid after done/start", int'(q_valid_o), 1);
        chk(int'(q_kind_o) == kind, req, "kind", int'(q_kind_o), kind);
        chk(int'(q_addr_o) == addr, req, "addr", int'(q_addr_o), addr);
        chk(int'(q_size_o) == size, "R2/R4", "size", int'(q_size_o), size);
        if (kind != 2) chk(int'(q_op_o) == op, "R8", "op", int'(q_op_o), op);
        for (int r = 0; r < retries; r++) begin
            q_retry_i = 1'b1;
            @(negedge clk);
            q_retry_i = 1'b0;
            chk(q_valid_o && int'(q_addr_o) == addr && int'(q_size_o) == size
                && int'(q_kind_o) == kind, "R5", "held after retry", int'(q_addr_o), addr);
        end
        q_accept_i = 1'b1;
        @(negedge clk);
        q_accept_i = 1'b0;
        chk(q_valid_o == 1'b0, "R6", "valid after accept", int'(q_valid_o), 0);
        for (int g = 0; g < gap; g++) begin
            if (poke && g == 0) begin
                start_i = 1'b1;
                start_addr_i = AW'(12'h5A3);
                end_addr_i = AW'(12'h0F1);
                op_i = 2'd1;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk(q_valid_o == 1'b0 && busy_o == 1'b1, "R6", "waiting for done",
                int'(q_valid_o), 0);
        end
        q_done_i = 1'b1;
        @(negedge clk);
        q_done_i = 1'b0;
    endtask

    task automatic run(input int s, input int e, input int op, input int tw, input bit poke);
        int sal, len, span, a, rem, c, idx;
        bit whole;
        sal = s & ~(LINE - 1);
        len = (e - sal) & AMSK;
        whole = (len >= (1 << AW) - LINE);
        span = (len + LINE - 1) & ~(LINE - 1);
        start_addr_i = AW'(s);
        end_addr_i = AW'(e);
        op_i = 2'(op);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
        if (whole) begin
            serve(1, 0, 0, op, tw % 3, tw % 4, poke, "R3");
        end else begin
            a = sal; rem = span; idx = 0;
            while (rem > 0) begin
                c = (rem < CMAX) ? rem : CMAX;
                serve(0, a, c, op, (tw + idx) % 3, (tw + idx) % 4, poke && idx == 0,
                      (idx == 0) ? "R1" : "R4");
                a = (a + c) & AMSK;
                rem -= c;
                idx++;
            end
        end
        serve(2, 0, 0, op, tw % 2, 1, 1'b0, "R7");
        chk(busy_o == 1'b0, poke ? "R9" : "R8", "busy after sync done", int'(busy_o), 0);
        chk(q_valid_o == 1'b0, "R8", "idle valid", int'(q_valid_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        report();
    end

    initial begin
        int deltas [15] = '{0, 1, 15, 16, 17, 47, 48, 49, 95, 96, 97, 200, 4079, 4080, 4095};
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && q_valid_o == 1'b0, "R10", "reset outputs",
            int'(busy_o) + int'(q_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: zero span sends sync only
        run(32, 32, 0, 0, 1'b0);
        // R3: wrap threshold exactly
        run(16, 0, 2, 1, 1'b0);
        // R9: start pokes while busy
        run(5, 130, 1, 2, 1'b1);
        run(4000, 4080, 2, 3, 1'b1);
        for (int si = 0; si < 16; si++) begin
            for (int di = 0; di < 15; di++) begin
                int s;
                s = (si * 257 + si) & AMSK;
                run(s, (s + deltas[di]) & AMSK, (si + di) % 3, si + di, 1'b0);
            end
        end
        report();
    end
endmodule